// File: doc/BRIEF.md
# I2C Target with Clock Stretching

This block is an I2C target (slave) that answers to a seven-bit address set by software. Bytes written by a bus controller land in a single data register. Bytes the controller reads are taken from that same register. After every received byte, and before every byte to be sent, the block holds SCL low. It keeps holding it until software has read or written the data register, so software never has to keep pace with the bus.

Software reaches the block through a small register port: a word address, write and read strobes, write data and combinational read data. Request bits tell software what the bus is waiting for. A flag marks the first data byte after the address. Start, stop and data events raise raw interrupt bits, which are masked and cleared by writing ones. The bus pins are open drain: each line has an input and an output-enable, and the output value is always low.

Top module: `i2c_stretch_target`

Register word offsets: 0 own address (bits 6:0); 1 status on read, control on write; 2 data; 3 interrupt mask; 4 raw interrupts; 5 masked interrupts; 6 interrupt clear. Status bits: 0 receive request, 1 transmit request, 2 first byte. Interrupt bits in mask, raw, masked and clear: 0 data, 1 start, 2 stop. Control bit 0 enables the target.

## Requirements
- R1: After reset, status, raw interrupts, the data register and irq_o read as zero, and neither SCL nor SDA is pulled low.
- R2: An address byte whose upper seven bits equal the own-address register is acknowledged with SDA low in the ninth clock. On a mismatch SDA stays released in that slot, and later bytes are neither acknowledged nor stretched until the next start.
- R3: While control bit 0 is clear, the block ignores the bus: it acknowledges nothing, pulls no line low and sets no interrupt bit.
- R4: When a write byte is received, status bit 0 is set and SCL is held low until software reads the data register (offset 2), which returns the byte and clears bit 0. The byte is then acknowledged.
- R5: Status bit 2 reads 1 while bit 0 is set for the first data byte after an address match, and 0 for later bytes. A read of the data register clears it.
- R6: When the block is addressed for a read (address bit 0 = 1), status bit 1 is set and SCL is held low until software writes the data register. That byte is then sent MSB first.
- R7: If the controller acknowledges a sent byte, status bit 1 is set again and SCL is held low. After a not-acknowledge the block releases both lines and raises no new transmit request.
- R8: A start (SDA falls while SCL is high) sets raw bit 1. A stop (SDA rises while SCL is high) sets raw bit 2. A received byte or a transmit request sets raw bit 0.
- R9: The masked register reads raw AND mask, and irq_o is high exactly when any masked bit is set.
- R10: Writing the clear register clears each raw bit written as 1 and leaves the bits written as 0 unchanged.
- R11: A write to offset 1 sets the enable bit. A read of offset 1 returns the status bits, not the enable bit.
- R12: The data register keeps its value until software writes it or a new byte is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register word offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effects on data read) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Interrupt, OR of masked bits |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output value, constant 0 |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value, constant 0 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except for start and stop. They also assume that every bus phase lasts longer than the few cycles of synchronizer delay, and that software reads or writes the data register only while the matching request is pending. The bench models a wired-AND bus with phases of 20 system cycles. It waits for SCL to actually go high before it samples, so stretching shows up as a stalled bit. It also services each request only after it has checked the request bit and the held line.

// File: rtl/i2c_st_pkg.sv
package i2c_st_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_OWN   = 3'd0;
  localparam logic [REG_AW-1:0] OFS_STAT  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_DATA  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_MASK  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_RAW   = 3'd4;
  localparam logic [REG_AW-1:0] OFS_MSKD  = 3'd5;
  localparam logic [REG_AW-1:0] OFS_CLR   = 3'd6;
  localparam int IRQ_DATA  = 0;
  localparam int IRQ_START = 1;
  localparam int IRQ_STOP  = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_HOLD, ST_RX_ACK,
    ST_TX_HOLD, ST_TX, ST_TX_ACK, ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_st_sync.sv
module i2c_st_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_p;
  assign scl_fall_o = ~scl_s & scl_p;
  assign start_o    = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o     = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_st_fsm.sv
module i2c_st_fsm
  import i2c_st_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic [6:0] own_addr_i,
  input  logic       rreq_i,
  input  logic       treq_i,
  input  logic [7:0] tx_byte_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       rx_valid_o,
  output logic       rx_first_o,
  output logic [7:0] rx_byte_o,
  output logic       tx_req_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  tgt_state_e state;
  logic [3:0] cnt;
  logic [7:0] sh, tx_sh;
  logic       rw, first_pend, mack_n;
  logic       live;

  assign live       = active_i & ~start_i & ~stop_i;
  assign rx_valid_o = live && state == ST_RX && scl_fall_i && cnt == 4'd8;
  assign rx_first_o = first_pend;
  assign rx_byte_o  = sh;
  assign tx_req_o   = live && scl_fall_i &&
                      ((state == ST_ADDR_ACK && rw) || (state == ST_TX_ACK && !mack_n));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE; cnt <= '0; sh <= '0; tx_sh <= '0;
      rw <= 1'b0; first_pend <= 1'b0; mack_n <= 1'b1;
      scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
    end else if (!active_i) begin
      state <= ST_IDLE; scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
    end else if (start_i) begin
      state <= ST_ADDR; cnt <= '0; scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE; scl_oe_o <= 1'b0; sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i) begin
            sh  <= {sh[6:0], sda_i};
            cnt <= cnt + 4'd1;
          end else if (scl_fall_i && cnt == 4'd8) begin
            if (state == ST_RX) begin
              scl_oe_o <= 1'b1;
              sda_oe_o <= 1'b1;
              first_pend <= 1'b0;
              state <= ST_RX_HOLD;
            end else if (sh[7:1] == own_addr_i) begin
              rw <= sh[0];
              sda_oe_o <= 1'b1;
              state <= ST_ADDR_ACK;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) begin
          sda_oe_o <= 1'b0;
          cnt <= '0;
          if (rw) begin
            scl_oe_o <= 1'b1;
            state <= ST_TX_HOLD;
          end else begin
            first_pend <= 1'b1;
            state <= ST_RX;
          end
        end
        ST_RX_HOLD: if (!rreq_i) begin
          scl_oe_o <= 1'b0;
          state <= ST_RX_ACK;
        end
        ST_RX_ACK: if (scl_fall_i) begin
          sda_oe_o <= 1'b0;
          cnt <= '0;
          state <= ST_RX;
        end
        ST_TX_HOLD: if (!treq_i) begin
          scl_oe_o <= 1'b0;
          sda_oe_o <= ~tx_byte_i[7];
          tx_sh <= tx_byte_i;
          cnt <= '0;
          state <= ST_TX;
        end
        ST_TX: if (scl_fall_i) begin
          cnt <= cnt + 4'd1;
          if (cnt == 4'd7) begin
            sda_oe_o <= 1'b0;
            state <= ST_TX_ACK;
          end else begin
            sda_oe_o <= ~tx_sh[6];
            tx_sh <= {tx_sh[6:0], 1'b0};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) mack_n <= sda_i;
          else if (scl_fall_i) begin
            if (!mack_n) begin
              scl_oe_o <= 1'b1;
              state <= ST_TX_HOLD;
            end else begin
              state <= ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_st_regs.sv
module i2c_st_regs
  import i2c_st_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_valid_i,
  input  logic              rx_first_i,
  input  logic [7:0]        rx_byte_i,
  input  logic              tx_req_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              active_o,
  output logic [6:0]        own_addr_o,
  output logic              rreq_o,
  output logic              treq_o,
  output logic [7:0]        data_o,
  output logic [2:0]        raw_o,
  output logic              irq_o
);
  logic [2:0] mask_q, set_v, clr_v;
  logic       first_q, data_rd, data_wr;

  assign data_rd = rd_i && addr_i == OFS_DATA;
  assign data_wr = wr_i && addr_i == OFS_DATA;

  always_comb begin
    set_v = '0;
    set_v[IRQ_DATA]  = rx_valid_i | tx_req_i;
    set_v[IRQ_START] = start_i & active_o;
    set_v[IRQ_STOP]  = stop_i & active_o;
    clr_v = (wr_i && addr_i == OFS_CLR) ? wdata_i[2:0] : 3'b000;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0; own_addr_o <= '0; mask_q <= '0; raw_o <= '0;
      rreq_o <= 1'b0; treq_o <= 1'b0; first_q <= 1'b0; data_o <= '0;
    end else begin
      if (wr_i && addr_i == OFS_OWN)  own_addr_o <= wdata_i[6:0];
      if (wr_i && addr_i == OFS_STAT) active_o   <= wdata_i[0];
      if (wr_i && addr_i == OFS_MASK) mask_q     <= wdata_i[2:0];
      raw_o <= (raw_o & ~clr_v) | set_v;
      if (rx_valid_i) begin
        rreq_o  <= 1'b1;
        first_q <= rx_first_i;
        data_o  <= rx_byte_i;
      end else begin
        if (data_rd) begin
          rreq_o  <= 1'b0;
          first_q <= 1'b0;
        end
        if (data_wr) data_o <= wdata_i;
      end
      if (tx_req_i)     treq_o <= 1'b1;
      else if (data_wr) treq_o <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_OWN:  rdata_o = {1'b0, own_addr_o};
      OFS_STAT: rdata_o = {5'b0, first_q & rreq_o, treq_o, rreq_o};
      OFS_DATA: rdata_o = data_o;
      OFS_MASK: rdata_o = {5'b0, mask_q};
      OFS_RAW:  rdata_o = {5'b0, raw_o};
      OFS_MSKD: rdata_o = {5'b0, raw_o & mask_q};
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(raw_o & mask_q);
endmodule

// File: rtl/i2c_stretch_target.sv
module i2c_stretch_target
  import i2c_st_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              irq_o,
  input  logic              scl_i,
  output logic              scl_o,
  output logic              scl_oe_o,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe_o
);
  logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       active, rreq, treq, rx_valid, rx_first, tx_req;
  logic [6:0] own_addr;
  logic [7:0] rx_byte, data_q;
  logic [2:0] raw;

  assign scl_o = 1'b0;
  assign sda_o = 1'b0;

  i2c_st_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  i2c_st_fsm u_fsm (
    .clk_i, .rst_ni, .active_i(active), .own_addr_i(own_addr),
    .rreq_i(rreq), .treq_i(treq), .tx_byte_i(data_q), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start_evt), .stop_i(stop_evt),
    .rx_valid_o(rx_valid), .rx_first_o(rx_first), .rx_byte_o(rx_byte), .tx_req_o(tx_req),
    .scl_oe_o, .sda_oe_o
  );

  i2c_st_regs u_regs (
    .clk_i, .rst_ni, .addr_i(reg_addr_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .rx_valid_i(rx_valid), .rx_first_i(rx_first), .rx_byte_i(rx_byte), .tx_req_i(tx_req),
    .start_i(start_evt), .stop_i(stop_evt),
    .active_o(active), .own_addr_o(own_addr), .rreq_o(rreq), .treq_o(treq),
    .data_o(data_q), .raw_o(raw), .irq_o
  );
endmodule

// File: rtl/i2c_stretch_target_chk.sv
module i2c_stretch_target_chk
  import i2c_st_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [7:0]        reg_wdata_i,
  input logic              active,
  input logic              rreq,
  input logic              treq,
  input logic              rx_valid,
  input logic              tx_req,
  input logic              start_evt,
  input logic              stop_evt,
  input logic [2:0]        raw,
  input logic              scl_oe_o,
  input logic              sda_oe_o
);
  logic data_rd, data_wr, clr_wr;
  assign data_rd = reg_rd_i && reg_addr_i == OFS_DATA;
  assign data_wr = reg_wr_i && reg_addr_i == OFS_DATA;
  assign clr_wr  = reg_wr_i && reg_addr_i == OFS_CLR;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(active) |-> (!scl_oe_o && !sda_oe_o)); // R3
  AST_RREQ_SERVICED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rreq && !rx_valid) |=> !rreq); // R4
  AST_STRETCH_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> (rreq || treq)); // R4
  AST_TREQ_SERVICED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && treq && !tx_req) |=> !treq); // R6
  AST_START_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw[IRQ_START]) |-> $past(start_evt)); // R8
  AST_STOP_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw[IRQ_STOP]) |-> $past(stop_evt)); // R8
  AST_CLEAR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr && reg_wdata_i[IRQ_START] && !start_evt) |=> !raw[IRQ_START]); // R10
endmodule

bind i2c_stretch_target i2c_stretch_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
  .reg_rd_i(reg_rd_i), .reg_wdata_i(reg_wdata_i), .active(active), .rreq(rreq),
  .treq(treq), .rx_valid(rx_valid), .tx_req(tx_req), .start_evt(start_evt),
  .stop_evt(stop_evt), .raw(raw), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o)
);

// File: tb/i2c_stretch_target_test.sv
`timescale 1ns/1ps
module i2c_stretch_target_test;
  localparam int T = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic irq, scl_o, scl_oe, sda_o, sda_oe;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_bus, sda_bus;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_stretch_target uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .scl_i(scl_bus), .scl_o(scl_o), .scl_oe_o(scl_oe),
    .sda_i(sda_bus), .sda_o(sda_o), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_scl_high();
    for (int i = 0; i < 5000 && !scl_bus; i++) @(negedge clk);
  endtask

  task automatic m_bit(input logic b, output logic s);
    sda_m = b; wait_n(T);
    scl_m = 1'b1; wait_scl_high(); wait_n(T);
    s = sda_bus;
    scl_m = 1'b0; wait_n(T);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wait_n(T);
    scl_m = 1'b1; wait_scl_high(); wait_n(T);
    sda_m = 1'b0; wait_n(T);
    scl_m = 1'b0; wait_n(T);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wait_n(T);
    scl_m = 1'b1; wait_scl_high(); wait_n(T);
    sda_m = 1'b1; wait_n(T);
  endtask

  task automatic m_bits(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) m_bit(b[i], s);
  endtask

  task automatic m_byte(input logic [7:0] b, output logic ack_n);
    m_bits(b);
    m_bit(1'b1, ack_n);
  endtask

  task automatic m_read(output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, s);
      b[i] = s;
    end
  endtask

  // controller raises SCL and checks that the target keeps it low
  task automatic check_held(input string req);
    sda_m = 1'b1; scl_m = 1'b1; wait_n(200);
    chk(scl_bus == 1'b0 && scl_oe == 1'b1, req, scl_bus, 0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    reg_rd(3'd1, d); chk(d == 8'h00, "R1 status", d, 0);
    reg_rd(3'd4, d); chk(d == 8'h00, "R1 raw", d, 0);
    reg_rd(3'd2, d); chk(d == 8'h00, "R1 data", d, 0);
    chk({irq, scl_oe, sda_oe} == 3'b000, "R1 pins", {irq, scl_oe, sda_oe}, 0);
  endtask

  task automatic t_inactive();
    logic a; logic [7:0] d;
    m_start();
    m_byte({7'h3A, 1'b0}, a);
    chk(a == 1'b1, "R3 no ack when off", a, 1);
    m_stop();
    reg_rd(3'd4, d); chk(d == 8'h00, "R3 raw untouched", d, 0);
  endtask

  task automatic t_rx();
    logic a; logic [7:0] d;
    m_start();
    reg_rd(3'd4, d); chk(d[1] == 1'b1, "R8 start raw", d, 2);
    chk(irq == 1'b1, "R9 irq on start", irq, 1);
    m_byte({7'h3A, 1'b0}, a);
    chk(a == 1'b0, "R2 address ack", a, 0);
    m_bits(8'hA5); wait_n(T);
    reg_rd(3'd1, d); chk(d == 8'h05, "R5 first byte flagged", d, 5);
    check_held("R4 SCL held on rx");
    reg_rd(3'd2, d); chk(d == 8'hA5, "R4 rx data", d, 8'hA5);
    reg_rd(3'd1, d); chk(d == 8'h00, "R5 cleared by read", d, 0);
    m_bit(1'b1, a); chk(a == 1'b0, "R4 byte acked", a, 0);
    m_bits(8'h3C); wait_n(T);
    reg_rd(3'd1, d); chk(d == 8'h01, "R5 second byte not first", d, 1);
    reg_rd(3'd2, d); chk(d == 8'h3C, "R4 second rx data", d, 8'h3C);
    m_bit(1'b1, a);
    m_stop();
    reg_rd(3'd4, d); chk(d == 8'h07, "R8 stop and data raw", d, 7);
    wait_n(100);
    reg_rd(3'd2, d); chk(d == 8'h3C, "R12 data retained", d, 8'h3C);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    reg_wr(3'd6, 8'h00);
    reg_rd(3'd4, d); chk(d == 8'h07, "R10 zero write no effect", d, 7);
    reg_wr(3'd6, 8'h02);
    reg_rd(3'd4, d); chk(d == 8'h05, "R10 clear start only", d, 5);
    reg_wr(3'd3, 8'h04);
    reg_rd(3'd5, d); chk(d == 8'h04 && irq, "R9 masked stop", d, 4);
    reg_wr(3'd3, 8'h02);
    reg_rd(3'd5, d); chk(d == 8'h00 && !irq, "R9 masked none", {irq, d}, 0);
    reg_wr(3'd6, 8'h07); reg_wr(3'd3, 8'h07);
    reg_rd(3'd4, d); chk(d == 8'h00, "R10 clear all", d, 0);
  endtask

  task automatic t_mismatch();
    logic a; logic [7:0] d;
    m_start();
    m_byte({7'h55, 1'b0}, a);
    chk(a == 1'b1, "R2 mismatch nack", a, 1);
    m_bits(8'h11); wait_n(T);
    chk(scl_oe == 1'b0, "R2 no stretch after mismatch", scl_oe, 0);
    m_bit(1'b1, a); chk(a == 1'b1, "R2 later byte ignored", a, 1);
    reg_rd(3'd1, d); chk(d == 8'h00, "R2 no request", d, 0);
    m_stop();
    reg_wr(3'd6, 8'h07);
  endtask

  task automatic t_tx();
    logic a; logic [7:0] d, b;
    m_start();
    m_byte({7'h3A, 1'b1}, a);
    chk(a == 1'b0, "R2 read address ack", a, 0);
    reg_rd(3'd1, d); chk(d == 8'h02, "R6 transmit request", d, 2);
    check_held("R6 SCL held on tx");
    reg_wr(3'd2, 8'h96);
    reg_rd(3'd1, d); chk(d == 8'h00, "R6 request cleared", d, 0);
    m_read(b); chk(b == 8'h96, "R6 tx byte MSB first", b, 8'h96);
    m_bit(1'b0, a);
    reg_rd(3'd1, d); chk(d == 8'h02, "R7 ack gives new request", d, 2);
    reg_wr(3'd2, 8'h5B);
    m_read(b); chk(b == 8'h5B, "R6 second tx byte", b, 8'h5B);
    m_bit(1'b1, a); wait_n(T);
    reg_rd(3'd1, d); chk(d == 8'h00, "R7 nack no request", d, 0);
    chk({scl_oe, sda_oe} == 2'b00, "R7 lines released", {scl_oe, sda_oe}, 0);
    m_stop();
    reg_rd(3'd2, d); chk(d == 8'h5B, "R12 tx data retained", d, 8'h5B);
  endtask

  task automatic t_shared();
    logic [7:0] d;
    reg_wr(3'd1, 8'h01);
    reg_rd(3'd1, d); chk(d == 8'h00, "R11 read gives status", d, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(2);
    t_reset();
    reg_wr(3'd0, 8'h3A); reg_wr(3'd3, 8'h07);
    t_inactive();
    reg_wr(3'd1, 8'h01);
    t_rx();
    t_clear();
    t_mismatch();
    t_tx();
    t_shared();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule